// File: doc/BRIEF.md
# Fall-Through-Indexed Branch Direction Table

This block gives a taken or not-taken guess for a conditional branch before the branch reaches execution. The lookahead logic gives it the address of the instruction that follows the branch, not the address of the branch itself. That address picks one of 512 sets, each with two ways. Every way stores a valid flag and a 6-bit folded partial tag. If the folded tag of the lookup address matches a valid way in the set, the guess is taken. Otherwise the guess is not taken and no redirect is implied. The result appears one cycle after the lookup is presented.

When a conditional branch resolves, the same fall-through address is sent back on the update port. Two flags come with it: whether the original lookup hit, and whether the branch was actually taken.
- A branch that missed but was taken installs an entry.
- A branch that hit but was not taken removes the entry.
- A correctly guessed branch leaves the table contents alone.

Each set has one replacement bit. It points at the way to evict next and moves on every hit and every install.

Top module: `bht_predictor`

## Requirements
- R1: Addresses are 64 bits, written here with bit 0 as the least significant bit. The set index is address bits [10:2]. The folded tag is {addr[31:28] ^ addr[16:13], addr[12:11]}, so bits [5:2] of the tag are the XOR fold. All other address bits have no effect on the guess.
- R2: `pred_valid_o` is high in exactly those cycles that follow a cycle with `lk_valid_i` high.
- R3: A lookup whose folded tag equals the tag of a valid way in its set, in either way, produces `pred_taken_o` high, and `pred_taken_o` is never high without `pred_valid_o`.
- R4: A lookup with no valid matching way produces `pred_valid_o` high with `pred_taken_o` low.
- R5: An update with was-hit low and taken high installs the folded tag in the indexed set, so a later lookup of that address predicts taken. If the tag is already present in the set, no second copy is made.
- R6: An update with was-hit high and taken low invalidates every way of the set that holds the folded tag, so a later lookup predicts not taken.
- R7: An update reporting a correct guess (hit and taken, or miss and not taken) changes no table entry.
- R8: An install takes an invalid way of the set if one exists, and otherwise the way named by the set's replacement bit. A lookup hit, a confirming hit-and-taken update, and an install each mark their way as most recently used.
- R9: A lookup and an update to the same set in the same cycle give the lookup the contents from before the update.
- R10: After reset every entry is invalid and both prediction outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 64 | Fall-through address of the branch being looked up |
| upd_valid_i | input | 1 | Resolved-branch update |
| upd_addr_i | input | 64 | Fall-through address of the resolved branch |
| upd_was_hit_i | input | 1 | The earlier lookup for this branch hit |
| upd_taken_i | input | 1 | The branch resolved taken |
| pred_valid_o | output | 1 | Prediction result valid |
| pred_taken_o | output | 1 | Predict taken |

## Verification
The internal state of this block shows up only through later lookups, so each bench scenario follows an update with lookups one cycle later.
- A wrong valid flag or tag shows as a flipped guess on the next lookup of that address.
- A wrong index or fold shows as an alias that should hit but misses, or one that should miss but hits.
- A replacement bit that went wrong stays hidden until the next install into that set. It then shows as the wrong older entry disappearing, which a lookup of the surviving and the evicted address reveals two cycles after the install.

// File: rtl/bht_pkg.sv
package bht_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned SETS   = 512;
  localparam int unsigned WAYS   = 2;
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = $clog2(WAYS);

  // field limits in MSB-0 numbering (bit 0 = most significant)
  localparam int unsigned IDX_END_M0    = 61;
  localparam int unsigned FOLD_A_END_M0 = 35;
  localparam int unsigned FOLD_B_END_M0 = 50;
  localparam int unsigned LOW_END_M0    = 52;
  localparam int unsigned FOLD_W        = 4;
  localparam int unsigned LOW_W         = 2;
  localparam int unsigned TAG_W         = FOLD_W + LOW_W;

  function automatic int unsigned lsb_of(int unsigned m0_pos);
    return ADDR_W - 1 - m0_pos;
  endfunction

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [WAY_W-1:0]  way_t;
endpackage

// File: rtl/bht_hash.sv
module bht_hash
  import bht_pkg::*;
(
  input  addr_t addr_i,
  output idx_t  idx_o,
  output tag_t  tag_o
);
  localparam int unsigned IDX_LSB  = lsb_of(IDX_END_M0);
  localparam int unsigned FA_LSB   = lsb_of(FOLD_A_END_M0);
  localparam int unsigned FB_LSB   = lsb_of(FOLD_B_END_M0);
  localparam int unsigned LOW_LSB  = lsb_of(LOW_END_M0);

  logic [FOLD_W-1:0] fold;

  always_comb begin
    idx_o = addr_i[IDX_LSB +: IDX_W];
    fold  = addr_i[FA_LSB +: FOLD_W] ^ addr_i[FB_LSB +: FOLD_W];
    tag_o = {fold, addr_i[LOW_LSB +: LOW_W]};
  end
endmodule

// File: rtl/bht_way.sv
module bht_way
  import bht_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  idx_t ra_idx_i,
  output logic ra_valid_o,
  output tag_t ra_tag_o,
  input  idx_t rb_idx_i,
  output logic rb_valid_o,
  output tag_t rb_tag_o,
  input  logic wr_en_i,
  input  idx_t wr_idx_i,
  input  tag_t wr_tag_i,
  input  logic clr_en_i,
  input  idx_t clr_idx_i
);
  logic [SETS-1:0] valid_q;
  tag_t            tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (clr_en_i) valid_q[clr_idx_i] <= 1'b0;
      if (wr_en_i)  valid_q[wr_idx_i]  <= 1'b1;
    end
  end

  // tags need no reset: valid guards them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_idx_i] <= wr_tag_i;
  end

  always_comb begin
    ra_valid_o = valid_q[ra_idx_i];
    ra_tag_o   = tag_q[ra_idx_i];
    rb_valid_o = valid_q[rb_idx_i];
    rb_tag_o   = tag_q[rb_idx_i];
  end
endmodule

// File: rtl/bht_lru.sv
module bht_lru
  import bht_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  idx_t rd_idx_i,
  output way_t victim_o,
  input  logic ta_en_i,
  input  idx_t ta_idx_i,
  input  way_t ta_way_i,
  input  logic tb_en_i,
  input  idx_t tb_idx_i,
  input  way_t tb_way_i
);
  // per set: way to evict next (two-way only)
  logic [SETS-1:0] victim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      victim_q <= '0;
    end else begin
      if (ta_en_i) victim_q[ta_idx_i] <= ~ta_way_i;
      // update port wins on same-set collision
      if (tb_en_i) victim_q[tb_idx_i] <= ~tb_way_i;
    end
  end

  assign victim_o = victim_q[rd_idx_i];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
  import bht_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lk_valid_i,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  input  logic                upd_valid_i,
  input  logic [ADDR_W-1:0]   upd_addr_i,
  input  logic                upd_was_hit_i,
  input  logic                upd_taken_i,
  output logic                pred_valid_o,
  output logic                pred_taken_o
);
  idx_t lk_idx, up_idx;
  tag_t lk_tag, up_tag;

  logic [WAYS-1:0] lk_v, up_v, lk_hit, up_hit, wr_en, clr_en;
  tag_t            lk_t [WAYS];
  tag_t            up_t [WAYS];

  way_t lru_victim, lk_way, up_match_way, free_way, fill_way, touch_way;
  logic free_found, up_any, lk_any;
  logic do_install, do_clear, do_confirm, touch_en;
  logic pred_valid_q, pred_taken_q;

  bht_hash u_hash_lk (.addr_i(lk_addr_i),  .idx_o(lk_idx), .tag_o(lk_tag));
  bht_hash u_hash_up (.addr_i(upd_addr_i), .idx_o(up_idx), .tag_o(up_tag));

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    bht_way u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ra_idx_i   (lk_idx),
      .ra_valid_o (lk_v[w]),
      .ra_tag_o   (lk_t[w]),
      .rb_idx_i   (up_idx),
      .rb_valid_o (up_v[w]),
      .rb_tag_o   (up_t[w]),
      .wr_en_i    (wr_en[w]),
      .wr_idx_i   (up_idx),
      .wr_tag_i   (up_tag),
      .clr_en_i   (clr_en[w]),
      .clr_idx_i  (up_idx)
    );
    assign lk_hit[w] = lk_v[w] && (lk_t[w] == lk_tag);
    assign up_hit[w] = up_v[w] && (up_t[w] == up_tag);
  end

  always_comb begin
    lk_way       = '0;
    up_match_way = '0;
    free_way     = '0;
    free_found   = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_hit[w]) lk_way       = way_t'(w);
      if (up_hit[w]) up_match_way = way_t'(w);
      if (!up_v[w]) begin
        free_way   = way_t'(w);
        free_found = 1'b1;
      end
    end
  end

  always_comb begin
    lk_any     = |lk_hit;
    up_any     = |up_hit;
    do_install = upd_valid_i && !upd_was_hit_i && upd_taken_i;
    do_clear   = upd_valid_i && upd_was_hit_i && !upd_taken_i;
    do_confirm = upd_valid_i && upd_was_hit_i && upd_taken_i;
    fill_way   = free_found ? free_way : lru_victim;
    for (int w = 0; w < WAYS; w++) begin
      wr_en[w]  = do_install && !up_any && (fill_way == way_t'(w));
      clr_en[w] = do_clear && up_hit[w];
    end
    touch_en  = (do_install || (do_confirm && up_any));
    touch_way = up_any ? up_match_way : fill_way;
  end

  bht_lru u_lru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (up_idx),
    .victim_o (lru_victim),
    .ta_en_i  (lk_valid_i && lk_any),
    .ta_idx_i (lk_idx),
    .ta_way_i (lk_way),
    .tb_en_i  (touch_en),
    .tb_idx_i (up_idx),
    .tb_way_i (touch_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q <= 1'b0;
      pred_taken_q <= 1'b0;
    end else begin
      pred_valid_q <= lk_valid_i;
      pred_taken_q <= lk_valid_i && lk_any;
    end
  end

  assign pred_valid_o = pred_valid_q;
  assign pred_taken_o = pred_taken_q;
endmodule

// File: rtl/bht_checker.sv
module bht_checker
  import bht_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_was_hit_i,
  input logic              upd_taken_i,
  input logic              pred_valid_o,
  input logic              pred_taken_o,
  input logic [WAYS-1:0]   lk_hit,
  input logic [WAYS-1:0]   up_hit
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> pred_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !pred_valid_o);

  a_r3_taken_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> pred_valid_o);

  a_r4_miss_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_hit == '0) |=> !pred_taken_o);

  a_r5_single_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit) && $onehot0(up_hit));

  a_r5_install_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_was_hit_i && upd_taken_i)
    ##1 (lk_valid_i && lk_addr_i == $past(upd_addr_i)) |=> pred_taken_o);

  a_r6_clear_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_was_hit_i && !upd_taken_i)
    ##1 (lk_valid_i && lk_addr_i == $past(upd_addr_i)) |=> !pred_taken_o);
endmodule

bind bht_predictor bht_checker u_bht_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .lk_valid_i    (lk_valid_i),
  .lk_addr_i     (lk_addr_i),
  .upd_valid_i   (upd_valid_i),
  .upd_addr_i    (upd_addr_i),
  .upd_was_hit_i (upd_was_hit_i),
  .upd_taken_i   (upd_taken_i),
  .pred_valid_o  (pred_valid_o),
  .pred_taken_o  (pred_taken_o),
  .lk_hit        (lk_hit),
  .up_hit        (up_hit)
);

// File: tb/tb_bht_predictor.sv
module tb_bht_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [63:0] lk_addr_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [63:0] upd_addr_i = '0;
  logic        upd_was_hit_i = 1'b0;
  logic        upd_taken_i = 1'b0;
  logic        pred_valid_o, pred_taken_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit    vld;
    bit    tkn;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  bht_predictor dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
    .upd_valid_i(upd_valid_i), .upd_addr_i(upd_addr_i),
    .upd_was_hit_i(upd_was_hit_i), .upd_taken_i(upd_taken_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o)
  );

  // address built from the R1 field layout
  function automatic logic [63:0] mk(int set, logic [5:0] tag, logic [3:0] mix,
                                     logic [31:0] hi, logic [10:0] noise);
    logic [63:0] a;
    a = '0;
    a[63:32] = hi;
    a[27:17] = noise;
    a[1:0]   = noise[1:0];
    a[10:2]  = set[8:0];
    a[12:11] = tag[1:0];
    a[16:13] = mix;
    a[31:28] = tag[5:2] ^ mix;
    return a;
  endfunction

  task automatic check(string req, bit got, bit exp, string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  // one cycle of stimulus; a lookup pushes its expected result
  task automatic step(bit lv, logic [63:0] la, bit lexp,
                      bit uv, logic [63:0] ua, bit wh, bit tk, string req);
    exp_t e;
    @(negedge clk_i);
    lk_valid_i    = lv;
    lk_addr_i     = la;
    upd_valid_i   = uv;
    upd_addr_i    = ua;
    upd_was_hit_i = wh;
    upd_taken_i   = tk;
    e.vld = lv;
    e.tkn = lv && lexp;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic look(logic [63:0] a, bit exp, string req);
    step(1'b1, a, exp, 1'b0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic upd(logic [63:0] a, bit wh, bit tk, string req);
    step(1'b0, '0, 1'b0, 1'b1, a, wh, tk, req);
  endtask

  // monitor: result of the stimulus from the previous negedge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, pred_valid_o, e.vld, "pred_valid_o");
        check(e.req, pred_taken_o, e.tkn, "pred_taken_o");
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] a, b, c, d, e_addr, p, q, r, s, t, u, v, w, x, y;
    repeat (3) @(negedge clk_i);
    check("R10", pred_valid_o, 1'b0, "valid in reset");
    check("R10", pred_taken_o, 1'b0, "taken in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10", pred_valid_o, 1'b0, "valid after reset");

    a = mk(5, 6'h2A, 4'h3, 32'h1234_5678, 11'h155);
    b = mk(5, 6'h2A, 4'hC, 32'hDEAD_BEEF, 11'h2AA);
    c = mk(5, 6'h2B, 4'h3, 32'h1234_5678, 11'h155);
    d = mk(6, 6'h2A, 4'h3, 32'h1234_5678, 11'h155);

    // R10 / R4: empty table
    look(a, 1'b0, "R10");
    look(d, 1'b0, "R4");
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    look(mk(511, 6'h3F, 4'hF, 32'hFFFF_FFFF, 11'h7FF), 1'b0, "R4");

    // R5 / R3 / R1
    upd(a, 1'b0, 1'b1, "R5");
    look(a, 1'b1, "R5");
    look(b, 1'b1, "R1");
    look(c, 1'b0, "R1");
    look(d, 1'b0, "R1");

    // R7: correct outcomes do not change contents
    upd(a, 1'b1, 1'b1, "R7");
    look(a, 1'b1, "R7");
    e_addr = mk(7, 6'h11, 4'h1, 32'h0, 11'h0);
    upd(e_addr, 1'b0, 1'b0, "R7");
    look(e_addr, 1'b0, "R7");

    // R6: wrong hit clears
    upd(b, 1'b1, 1'b0, "R6");
    look(a, 1'b0, "R6");

    // R8: LRU replacement
    p = mk(20, 6'h01, 4'h0, 32'h0, 11'h0);
    q = mk(20, 6'h02, 4'h0, 32'h0, 11'h0);
    r = mk(20, 6'h03, 4'h0, 32'h0, 11'h0);
    upd(p, 1'b0, 1'b1, "R8");
    upd(q, 1'b0, 1'b1, "R8");
    look(p, 1'b1, "R8");
    upd(r, 1'b0, 1'b1, "R8");
    look(q, 1'b0, "R8");
    look(p, 1'b1, "R8");
    look(r, 1'b1, "R3");

    // R8: invalid way chosen before the LRU way
    s = mk(30, 6'h05, 4'h9, 32'h0, 11'h0);
    t = mk(30, 6'h06, 4'h9, 32'h0, 11'h0);
    u = mk(30, 6'h07, 4'h9, 32'h0, 11'h0);
    upd(s, 1'b0, 1'b1, "R8");
    upd(t, 1'b0, 1'b1, "R8");
    upd(t, 1'b1, 1'b0, "R6");
    upd(u, 1'b0, 1'b1, "R8");
    look(s, 1'b1, "R8");
    look(u, 1'b1, "R8");
    look(t, 1'b0, "R6");

    // R8 / R7: confirming update refreshes recency
    v = mk(40, 6'h10, 4'h5, 32'h0, 11'h0);
    w = mk(40, 6'h20, 4'h5, 32'h0, 11'h0);
    x = mk(40, 6'h30, 4'h5, 32'h0, 11'h0);
    upd(v, 1'b0, 1'b1, "R8");
    upd(w, 1'b0, 1'b1, "R8");
    upd(v, 1'b1, 1'b1, "R7");
    upd(x, 1'b0, 1'b1, "R8");
    look(w, 1'b0, "R8");
    look(v, 1'b1, "R8");
    look(x, 1'b1, "R8");

    // R5: reinstall of a present tag keeps the other way
    upd(x, 1'b0, 1'b1, "R5");
    look(v, 1'b1, "R5");
    upd(x, 1'b1, 1'b0, "R6");
    look(x, 1'b0, "R5");

    // R9: same-cycle update and lookup see old contents
    y = mk(50, 6'h15, 4'h6, 32'h0, 11'h0);
    step(1'b1, y, 1'b0, 1'b1, y, 1'b0, 1'b1, "R9");
    look(y, 1'b1, "R9");
    step(1'b1, y, 1'b1, 1'b1, y, 1'b1, 1'b0, "R9");
    look(y, 1'b0, "R9");

    // drain
    repeat (3) step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2");
    @(negedge clk_i);
    @(negedge clk_i);
    check("R2", exp_q.size() == 0, 1'b1, "scoreboard drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule